// File: doc/BRIEF.md
# Sleep-Mode Bus Clock Keep-Alive Register

This block is a single 32-bit control word with one keep-alive bit per bus peripheral, for up to eight peripherals. A set bit keeps that peripheral's bus clock running while the system is in a low-power state (Sleep or Stop). A clear bit lets clock gating remove the clock during that state. The block also drives a registered per-peripheral clock enable for the gating cells. While the system runs, that enable follows the run-mode enable. While the sleep input is high, it follows the register bit. The register bit is also brought out as a flag that says whether the peripheral can wake from Stop mode.

Software reaches the word through a plain register slave port with a request strobe, write enable, address, write data and registered read data. Each access carries a secure attribute and a privileged attribute. Every bit has its own security attribute, taken from a mask input, and one bit (the security controller's own) is forced secure while the global security enable is high. Bits that an access may not touch read as zero and ignore the write. There is no error response. A privilege filter can be switched on separately for the secure side and for the non-secure side.

Top module: `smcg_sleep_clk_ctrl`

## Requirements
- R1: After reset all keep-alive bits are 0, `rdata_o` is 0, `gated_en_o` is 0 and `wake_cap_o` is 0.
- R2: A write (`req_i`=1, `we_i`=1) to address `REG_OFFSET` (default 0x10) by a secure privileged access stores `wdata_i[7:0]` in the clock edge that samples it. A read (`req_i`=1, `we_i`=0) returns the word on `rdata_o` one cycle after the strobe, with bit i holding peripheral i.
- R3: `wake_cap_o[i]` equals the stored keep-alive bit i.
- R4: `gated_en_o` is registered. At the edge after the sleep input is sampled, it takes `run_en_i` when `sleep_i`=0 and the stored bits when `sleep_i`=1.
- R5: A bit with `sec_mask_i[i]`=1 is secure. A non-secure access (`secure_i`=0) reads it as 0 and leaves it unchanged on write.
- R6: While `global_sec_en_i`=1, bit `SEC_CTRL_BIT` (default 1) is secure whatever `sec_mask_i` says.
- R7: While `spriv_only_i`=1, an unprivileged access (`priv_i`=0) reads secure bits as 0 and cannot change them. A privileged secure access is unaffected.
- R8: While `nspriv_only_i`=1, an unprivileged access reads non-secure bits as 0 and cannot change them.
- R9: Bits 31:8 of the word always read 0, and writes to them have no effect.
- R10: A write to any other address changes no bit. A read of any other address, and any cycle without a read, gives `rdata_o`=0.
- R11: Filtering is applied bit by bit. In one write, the permitted bits take the new data and the blocked bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | 32 | Read data, one cycle after the strobe |
| sec_mask_i | input | N_PERIPH | Per-bit security attribute, 1 = secure |
| global_sec_en_i | input | 1 | Global security enable |
| spriv_only_i | input | 1 | Secure bits need privileged access |
| nspriv_only_i | input | 1 | Non-secure bits need privileged access |
| sleep_i | input | 1 | System is in Sleep or Stop mode |
| run_en_i | input | N_PERIPH | Run-mode bus clock enables |
| gated_en_o | output | N_PERIPH | Registered bus clock enables for the gating cells |
| wake_cap_o | output | N_PERIPH | Peripheral may wake from Stop mode |

## Verification
The assertions assume that the security mask, the global security enable and both privilege controls hold steady through an access. They also assume that the secure and privileged attributes are valid whenever `req_i` is high. The bench changes those controls only on idle cycles between accesses. It drives every access for exactly one cycle, away from the sampling edge. It moves `sleep_i` and `run_en_i` only while no write is in flight, so each gated enable value can be traced to a single cause.

// File: rtl/smcg_pkg.sv
package smcg_pkg;

  localparam int unsigned SMCG_WORD_W = 32;

  typedef struct packed {
    logic secure;
    logic priv;
  } smcg_attr_t;

  // bit-level permission: secure bits need a secure access, then the matching privilege filter applies
  function automatic logic smcg_bit_grant(input logic is_sec, input smcg_attr_t a,
                                          input logic sp_only, input logic nsp_only);
    if (is_sec) return a.secure & (a.priv | ~sp_only);
    else        return a.priv | ~nsp_only;
  endfunction

endpackage

// File: rtl/smcg_access_filter.sv
module smcg_access_filter
  import smcg_pkg::*;
#(
  parameter int unsigned N_PERIPH     = 8,
  parameter int unsigned SEC_CTRL_BIT = 1
) (
  input  smcg_attr_t          attr_i,
  input  logic [N_PERIPH-1:0] sec_mask_i,
  input  logic                global_sec_en_i,
  input  logic                spriv_only_i,
  input  logic                nspriv_only_i,
  output logic [N_PERIPH-1:0] eff_sec_o,
  output logic [N_PERIPH-1:0] grant_o
);

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_bit
    if (i == SEC_CTRL_BIT) begin : g_ctrl
      assign eff_sec_o[i] = sec_mask_i[i] | global_sec_en_i;
    end else begin : g_plain
      assign eff_sec_o[i] = sec_mask_i[i];
    end
    assign grant_o[i] = smcg_bit_grant(eff_sec_o[i], attr_i, spriv_only_i, nspriv_only_i);
  end

endmodule

// File: rtl/smcg_enable_bank.sv
module smcg_enable_bank #(
  parameter int unsigned N_PERIPH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [N_PERIPH-1:0] wdata_i,
  input  logic [N_PERIPH-1:0] grant_i,
  output logic [N_PERIPH-1:0] bits_o
);

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    bit_q <= 1'b0;
      else if (wr_en_i && grant_i[i]) bit_q <= wdata_i[i];
    end

    assign bits_o[i] = bit_q;

    // R11
    blocked_bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !grant_i[i]) |=> $stable(bits_o[i]));

    // R10
    idle_bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(bits_o[i]));
  end

endmodule

// File: rtl/smcg_gate_sel.sv
module smcg_gate_sel #(
  parameter int unsigned N_PERIPH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_i,
  input  logic [N_PERIPH-1:0] run_en_i,
  input  logic [N_PERIPH-1:0] keep_i,
  output logic [N_PERIPH-1:0] gated_en_o
);

  logic [N_PERIPH-1:0] gated_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gated_q <= '0;
    else if (sleep_i) gated_q <= keep_i;
    else              gated_q <= run_en_i;
  end

  assign gated_en_o = gated_q;

  // R4
  sleep_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ((gated_en_o & ~$past(keep_i)) == '0));

  // R4
  run_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> ((gated_en_o & ~$past(run_en_i)) == '0));

endmodule

// File: rtl/smcg_sleep_clk_ctrl.sv
module smcg_sleep_clk_ctrl
  import smcg_pkg::*;
#(
  parameter int unsigned N_PERIPH     = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h10,
  parameter int unsigned SEC_CTRL_BIT = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [SMCG_WORD_W-1:0] wdata_i,
  input  logic                   secure_i,
  input  logic                   priv_i,
  output logic [SMCG_WORD_W-1:0] rdata_o,
  input  logic [N_PERIPH-1:0]    sec_mask_i,
  input  logic                   global_sec_en_i,
  input  logic                   spriv_only_i,
  input  logic                   nspriv_only_i,
  input  logic                   sleep_i,
  input  logic [N_PERIPH-1:0]    run_en_i,
  output logic [N_PERIPH-1:0]    gated_en_o,
  output logic [N_PERIPH-1:0]    wake_cap_o
);

  localparam int unsigned WORD_W = SMCG_WORD_W;

  smcg_attr_t          attr;
  logic                addr_hit, wr_hit, rd_hit;
  logic [N_PERIPH-1:0] eff_sec, grant, keep_bits;
  logic [WORD_W-1:0]   rd_word, rdata_q;

  assign attr     = '{secure: secure_i, priv: priv_i};
  assign addr_hit = (addr_i == REG_OFFSET);
  assign wr_hit   = req_i & we_i & addr_hit;
  assign rd_hit   = req_i & ~we_i & addr_hit;

  if (N_PERIPH < WORD_W) begin : g_pad
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[WORD_W-1:N_PERIPH];
  end

  smcg_access_filter #(
    .N_PERIPH    (N_PERIPH),
    .SEC_CTRL_BIT(SEC_CTRL_BIT)
  ) i_filter (
    .attr_i         (attr),
    .sec_mask_i     (sec_mask_i),
    .global_sec_en_i(global_sec_en_i),
    .spriv_only_i   (spriv_only_i),
    .nspriv_only_i  (nspriv_only_i),
    .eff_sec_o      (eff_sec),
    .grant_o        (grant)
  );

  smcg_enable_bank #(
    .N_PERIPH(N_PERIPH)
  ) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_hit),
    .wdata_i(wdata_i[N_PERIPH-1:0]),
    .grant_i(grant),
    .bits_o (keep_bits)
  );

  smcg_gate_sel #(
    .N_PERIPH(N_PERIPH)
  ) i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .run_en_i  (run_en_i),
    .keep_i    (keep_bits),
    .gated_en_o(gated_en_o)
  );

  // hidden bits and the unused upper word read as zero
  assign rd_word = WORD_W'(keep_bits & grant);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_word;
    else             rdata_q <= '0;
  end

  assign rdata_o    = rdata_q;
  assign wake_cap_o = keep_bits;

  // R5
  ns_read_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !secure_i) |=> ((rdata_o[N_PERIPH-1:0] & $past(eff_sec)) == '0));

  // R6
  ctrl_bit_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !secure_i && global_sec_en_i) |=> !rdata_o[SEC_CTRL_BIT]);

  // R2
  read_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> ((rdata_o[N_PERIPH-1:0] & ~$past(keep_bits)) == '0));

  // R10
  no_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> (rdata_o == '0));

endmodule

// File: tb/test_smcg_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module test_smcg_sleep_clk_ctrl;

  localparam logic [7:0] REG_A = 8'h10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, sec = 1'b0, priv = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  mask = '0, run_en = '0, gated, wake;
  logic        gse = 1'b0, sp = 1'b0, nsp = 1'b0, sleep = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] model = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  smcg_sleep_clk_ctrl i_smcg_sleep_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .secure_i(sec), .priv_i(priv), .rdata_o(rdata),
    .sec_mask_i(mask), .global_sec_en_i(gse), .spriv_only_i(sp),
    .nspriv_only_i(nsp), .sleep_i(sleep), .run_en_i(run_en),
    .gated_en_o(gated), .wake_cap_o(wake)
  );

  function automatic logic [7:0] grant_f(input logic s, input logic p);
    logic [7:0] g;
    for (int i = 0; i < 8; i++) begin
      logic is_sec;
      is_sec = mask[i] | ((i == 1) && gse);
      g[i] = is_sec ? (s & (p | ~sp)) : (p | ~nsp);
    end
    return g;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic s, input logic p);
    logic [7:0] g;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; sec = s; priv = p;
    g = grant_f(s, p);
    if (a == REG_A) model = (model & ~g) | (d[7:0] & g);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic s, input logic p, input string r);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; sec = s; priv = p;
    exp_q.push_back((a == REG_A) ? {24'h0, model & grant_f(s, p)} : 32'h0);
    tag_q.push_back(r);
    @(negedge clk);
    req = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_pend <= req && !we;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, rdata, e);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", rdata, 32'h0);
    chk("R1", {24'h0, gated}, 32'h0);
    chk("R1", {24'h0, wake}, 32'h0);
    rst_ni = 1'b1;

    wr(REG_A, 32'h0000_00A5, 1'b1, 1'b1);
    chk("R3", {24'h0, wake}, {24'h0, model});
    rd(REG_A, 1'b1, 1'b1, "R2");

    wr(REG_A, 32'hFFFF_FFFF, 1'b1, 1'b1);
    rd(REG_A, 1'b1, 1'b1, "R9");

    wr(8'h00, 32'h0000_0000, 1'b1, 1'b1);
    rd(REG_A, 1'b1, 1'b1, "R10");
    rd(8'h00, 1'b1, 1'b1, "R10");

    wr(REG_A, 32'h0000_003C, 1'b1, 1'b1);
    run_en = 8'h0F; sleep = 1'b0;
    @(negedge clk);
    chk("R4", {24'h0, gated}, 32'h0F);
    sleep = 1'b1;
    @(negedge clk);
    chk("R4", {24'h0, gated}, {24'h0, model});
    wr(REG_A, 32'h0000_0081, 1'b1, 1'b1);
    @(negedge clk);
    chk("R4", {24'h0, gated}, 32'h81);
    sleep = 1'b0;
    @(negedge clk);
    chk("R4", {24'h0, gated}, 32'h0F);

    mask = 8'hF0;
    wr(REG_A, 32'h0, 1'b0, 1'b1);
    rd(REG_A, 1'b0, 1'b1, "R5");
    rd(REG_A, 1'b1, 1'b1, "R5");
    wr(REG_A, 32'h0000_000F, 1'b0, 1'b1);
    rd(REG_A, 1'b1, 1'b1, "R11");

    mask = 8'h00; gse = 1'b1;
    rd(REG_A, 1'b0, 1'b1, "R6");
    wr(REG_A, 32'h0, 1'b0, 1'b1);
    rd(REG_A, 1'b1, 1'b1, "R6");
    gse = 1'b0;

    sp = 1'b1; mask = 8'h0F;
    wr(REG_A, 32'h0000_00FF, 1'b1, 1'b0);
    rd(REG_A, 1'b1, 1'b0, "R7");
    rd(REG_A, 1'b1, 1'b1, "R7");
    wr(REG_A, 32'h0, 1'b1, 1'b1);
    sp = 1'b0;

    nsp = 1'b1;
    wr(REG_A, 32'h0000_00FF, 1'b0, 1'b0);
    rd(REG_A, 1'b1, 1'b1, "R8");
    wr(REG_A, 32'h0000_00FF, 1'b1, 1'b0);
    rd(REG_A, 1'b1, 1'b1, "R8");
    nsp = 1'b0;
    chk("R3", {24'h0, wake}, {24'h0, model});

    repeat (3) @(negedge clk);
    chk("R2", exp_q.size(), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule